// File: doc/BRIEF.md
# Integer Multiply Unit with Overflow Flags

This unit performs integer multiplication for a 64-bit datapath. Each accepted request carries two 64-bit operands, a two-bit operation select, a signed flag, an overflow-record enable and a summary-overflow bit. One cycle later the unit presents a 64-bit result, a two-bit overflow field and the summary-overflow bit, all registered. Four operations are offered: the low or high half of a 32x32 product, and the low or high half of a 64x64 product. Signed products are formed from operand magnitudes. The magnitude product is negated when the two operand signs disagree.

A two-state controller tracks the output register. In `ST_IDLE` no result is presented. The `accept` transition (ST_IDLE to ST_EMIT) fires on `in_valid`. In `ST_EMIT` the result is presented for one cycle. From there, `stream` (ST_EMIT to ST_EMIT) fires when a new request arrives in the same cycle, and `drain` (ST_EMIT to ST_IDLE) fires when none does. `wait` keeps ST_IDLE while no request arrives.

Between requests the output registers hold their last contents.

Top module: `mul_unit`

## Requirements
- R1: `out_valid` is 1 exactly in the cycle after `in_valid` was sampled high, and 0 otherwise. While no request is accepted, `result` and `ov_flags` keep their last values.
- R2: With `op_sel`=0 (low word) and `is_signed`=1, `result` is the full 64-bit signed product of the sign-extended operand bits 31..0.
- R3: With `op_sel`=0 and `is_signed`=0, `result` is the 64-bit unsigned product of operand bits 31..0. Every unsigned operation returns `ov_flags`=00.
- R4: With `op_sel`=1 (high word), bits 63..32 of the 64-bit word product are returned in both `result[63:32]` and `result[31:0]`. The product is signed or unsigned according to `is_signed`.
- R5: With `op_sel`=2 (low doubleword), `result` is bits 63..0 of the signed 128-bit product. `is_signed` has no effect on either the result or the overflow.
- R6: With `op_sel`=3 (high doubleword), `result` is bits 127..64 of the 128-bit product. The product is signed or unsigned according to `is_signed`.
- R7: For a signed low-word operation, the overflow is set when bits 63..31 of the product are neither all zeros nor all ones.
- R8: For the low-doubleword operation, the overflow is set when bits 127..63 of the product are neither all zeros nor all ones.
- R9: `ov_flags[1]` (OV) and `ov_flags[0]` (OV32) always carry the same value. Both are 0 when `ov_en` was 0 for the request.
- R10: High-half operations (`op_sel`=1 or 3) never set `ov_flags`.
- R11: `so_out` equals the `so_in` sampled with the request.
- R12: After reset, `out_valid`, `result`, `ov_flags` and `so_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| op_sel | input | 2 | 0 low word, 1 high word, 2 low doubleword, 3 high doubleword |
| is_signed | input | 1 | Signed operation when 1 |
| ov_en | input | 1 | Record overflow when 1 |
| so_in | input | 1 | Summary-overflow bit to carry along |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Product or product half |
| ov_flags | output | 2 | Bit 1 OV, bit 0 OV32 |
| so_out | output | 1 | Carried summary-overflow bit |

## Verification
Overflow detection and summary-overflow pass-through land in the same output register in the same cycle. The bench drives overflow-producing corner operands (most negative value, -1, most positive value) while it toggles `so_in` and `ov_en` independently. The scoreboard judges the result, the overflow pair and the carried bit as separate checks against a reference product formed from extended operands. A back-to-back stream also makes a new capture coincide with the presentation of the previous result, so the `stream` transition is exercised under the same comparisons.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic [1:0] {
        OP_LO_W = 2'd0,
        OP_HI_W = 2'd1,
        OP_LO_D = 2'd2,
        OP_HI_D = 2'd3
    } mul_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } mul_state_e;

endpackage

// File: rtl/mul_mag.sv
// Operand conditioning: picks the word or doubleword view, reports its sign
// (only when the operation is signed) and returns the magnitude.
module mul_mag #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] value_i,
    input  logic            word_i,
    input  logic            signed_i,
    output logic [XLEN-1:0] mag_o,
    output logic            sign_o
);
    localparam int HALF = XLEN / 2;
    localparam logic [HALF-1:0] ONE_H = HALF'(1);
    localparam logic [XLEN-1:0] ONE_X = XLEN'(1);

    logic [HALF-1:0] lo;

    always_comb begin
        lo = value_i[HALF-1:0];
        if (word_i) begin
            sign_o = signed_i & lo[HALF-1];
            mag_o  = {{HALF{1'b0}}, (sign_o ? (~lo + ONE_H) : lo)};
        end else begin
            sign_o = signed_i & value_i[XLEN-1];
            mag_o  = sign_o ? (~value_i + ONE_X) : value_i;
        end
    end
endmodule

// File: rtl/mul_ovf_check.sv
// Sign-extension test: a field fits when its bits are all equal.
module mul_ovf_check #(
    parameter int W = 33
) (
    input  logic [W-1:0] bits_i,
    output logic         ovf_o
);
    always_comb ovf_o = (|bits_i) & ~(&bits_i);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
    import mul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  mul_op_e         op_i,
    input  logic            signed_i,
    input  logic            ov_en_i,
    output logic [XLEN-1:0] result_o,
    output logic [1:0]      ov_flags_o
);
    localparam int HALF = XLEN / 2;
    localparam int PW   = 2 * XLEN;
    localparam logic [PW-1:0] ONE_P = PW'(1);

    logic            word_op;
    logic            eff_signed;
    logic [XLEN-1:0] opnd [2];
    logic [XLEN-1:0] mag  [2];
    logic [1:0]      sgn;
    logic [PW-1:0]   mag_prod;
    logic [PW-1:0]   prod;
    logic            ovf_word;
    logic            ovf_dword;
    logic            raw_ov;

    always_comb begin
        word_op    = (op_i == OP_LO_W) || (op_i == OP_HI_W);
        // the low doubleword form exists only as a signed operation
        eff_signed = signed_i | (op_i == OP_LO_D);
        opnd[0]    = a_i;
        opnd[1]    = b_i;
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_opnd
        mul_mag #(.XLEN(XLEN)) u_mag (
            .value_i (opnd[gi]),
            .word_i  (word_op),
            .signed_i(eff_signed),
            .mag_o   (mag[gi]),
            .sign_o  (sgn[gi])
        );
    end

    always_comb begin
        mag_prod = {{XLEN{1'b0}}, mag[0]} * {{XLEN{1'b0}}, mag[1]};
        prod     = (sgn[0] ^ sgn[1]) ? (~mag_prod + ONE_P) : mag_prod;
    end

    mul_ovf_check #(.W(HALF + 1)) u_ovf_word (
        .bits_i(prod[XLEN-1:HALF-1]),
        .ovf_o (ovf_word)
    );

    mul_ovf_check #(.W(XLEN + 1)) u_ovf_dword (
        .bits_i(prod[PW-1:XLEN-1]),
        .ovf_o (ovf_dword)
    );

    always_comb begin
        unique case (op_i)
            OP_LO_W: begin
                result_o = prod[XLEN-1:0];
                raw_ov   = eff_signed & ovf_word;
            end
            OP_HI_W: begin
                result_o = {2{prod[XLEN-1:HALF]}};
                raw_ov   = 1'b0;
            end
            OP_LO_D: begin
                result_o = prod[XLEN-1:0];
                raw_ov   = ovf_dword;
            end
            OP_HI_D: begin
                result_o = prod[PW-1:XLEN];
                raw_ov   = 1'b0;
            end
        endcase
        ov_flags_o = ov_en_i ? {2{raw_ov}} : 2'b00;
    end
endmodule

// File: rtl/mul_unit.sv
module mul_unit
    import mul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [1:0]      op_sel,
    input  logic            is_signed,
    input  logic            ov_en,
    input  logic            so_in,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic [1:0]      ov_flags,
    output logic            so_out
);
    localparam int HALF = XLEN / 2;

    mul_state_e      state_q, state_d;
    logic [XLEN-1:0] dp_result;
    logic [1:0]      dp_ov;

    mul_datapath #(.XLEN(XLEN)) u_dp (
        .a_i       (op_a),
        .b_i       (op_b),
        .op_i      (mul_op_e'(op_sel)),
        .signed_i  (is_signed),
        .ov_en_i   (ov_en),
        .result_o  (dp_result),
        .ov_flags_o(dp_ov)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, wait, stream, drain
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            ov_flags <= 2'b00;
            so_out   <= 1'b0;
        end else if (in_valid) begin
            result   <= dp_result;
            ov_flags <= dp_ov;
            so_out   <= so_in;
        end
    end

    always_comb out_valid = (state_q == ST_EMIT);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(ov_flags)));
    p_unsigned_no_ov_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_signed && op_sel != 2'd2) |=> (ov_flags == 2'b00));
    p_hi_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd1) |=> (result[XLEN-1:HALF] == result[HALF-1:0]));
    p_ov_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ov_flags[1] == ov_flags[0]));
    p_ov_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ov_en) |=> (ov_flags == 2'b00));
    p_hi_no_ov_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[0]) |=> (ov_flags == 2'b00));
    p_so_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (so_out == $past(so_in)));
endmodule

// File: tb/tb_mul_unit.sv
module tb_mul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  op_sel = '0;
    logic        is_signed = 1'b0;
    logic        ov_en = 1'b0;
    logic        so_in = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic [1:0]  ov_flags;
    logic        so_out;

    int checks = 0;
    int failures = 0;
    logic [63:0] last_res = '0;
    logic [1:0]  last_ov = '0;

    logic [63:0] q_res [$];
    logic [1:0]  q_ov  [$];
    logic        q_so  [$];
    string       q_rt  [$];
    string       q_ot  [$];

    always #4 clk = ~clk;

    mul_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .is_signed(is_signed), .ov_en(ov_en), .so_in(so_in),
        .out_valid(out_valid), .result(result),
        .ov_flags(ov_flags), .so_out(so_out)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference: multiply extended operands, take the needed bits
    task automatic model(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] op, input logic sg, input logic ove,
                         output logic [63:0] r, output logic [1:0] ov);
        logic [63:0]  ea, eb, wp;
        logic [127:0] da, db, dp;
        logic         sgd, ovf;
        ea = sg ? {{32{a[31]}}, a[31:0]} : {32'b0, a[31:0]};
        eb = sg ? {{32{b[31]}}, b[31:0]} : {32'b0, b[31:0]};
        wp = ea * eb;
        sgd = sg | (op == 2'd2);
        da = sgd ? {{64{a[63]}}, a} : {64'b0, a};
        db = sgd ? {{64{b[63]}}, b} : {64'b0, b};
        dp = da * db;
        ovf = 1'b0;
        case (op)
            2'd0: begin
                r = wp;
                ovf = sg && !(wp[63:31] == '0 || wp[63:31] == {33{1'b1}});
            end
            2'd1: r = {wp[63:32], wp[63:32]};
            2'd2: begin
                r = dp[63:0];
                ovf = !(dp[127:63] == '0 || dp[127:63] == {65{1'b1}});
            end
            default: r = dp[127:64];
        endcase
        ov = (ove && ovf) ? 2'b11 : 2'b00;
    endtask

    task automatic send(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] op, input logic sg,
                        input logic ove, input logic so);
        logic [63:0] r;
        logic [1:0]  ov;
        string rt, ot;
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; op_sel = op;
        is_signed = sg; ov_en = ove; so_in = so;
        model(a, b, op, sg, ove, r, ov);
        case (op)
            2'd0: rt = sg ? "R2" : "R3";
            2'd1: rt = "R4";
            2'd2: rt = "R5";
            default: rt = "R6";
        endcase
        if (!ove) ot = "R9";
        else if (op[0]) ot = "R10";
        else if (op == 2'd2) ot = "R8";
        else ot = sg ? "R7" : "R3";
        q_res.push_back(r); q_ov.push_back(ov); q_so.push_back(so);
        q_rt.push_back(rt); q_ot.push_back(ot);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        op_a = $urandom(); op_b = $urandom();
        ov_en = 1'b1; so_in = ~so_in;
        if (n > 1) repeat (n - 1) @(negedge clk);
    endtask

    // monitor: pops the scoreboard when a result appears
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_res.size() == 0) begin
                chk(1'b0, "R1", "unexpected out_valid", 64'd1, 64'd0);
            end else begin
                logic [63:0] er;
                logic [1:0]  eo;
                logic        es;
                string       rt, ot;
                er = q_res.pop_front(); eo = q_ov.pop_front();
                es = q_so.pop_front();
                rt = q_rt.pop_front(); ot = q_ot.pop_front();
                chk(result === er, rt, "result", result, er);
                chk(ov_flags === eo, ot, "ov_flags", {62'b0, ov_flags}, {62'b0, eo});
                chk(so_out === es, "R11", "so_out", {63'b0, so_out}, {63'b0, es});
                last_res = er; last_ov = eo;
            end
        end
    end

    task automatic hold_check();
        idle(3);
        chk(out_valid == 1'b0, "R1", "out_valid idle", {63'b0, out_valid}, 64'd0);
        chk(result === last_res, "R1", "result held", result, last_res);
        chk(ov_flags === last_ov, "R1", "ov held", {62'b0, ov_flags}, {62'b0, last_ov});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] corner [8];
        corner[0] = 64'd0;
        corner[1] = '1;
        corner[2] = 64'h8000_0000_0000_0000;
        corner[3] = 64'h7FFF_FFFF_FFFF_FFFF;
        corner[4] = 64'h0000_0000_8000_0000;
        corner[5] = 64'h0000_0000_7FFF_FFFF;
        corner[6] = 64'h0000_0000_FFFF_FFFF;
        corner[7] = 64'd3;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk(out_valid == 1'b0, "R12", "out_valid", {63'b0, out_valid}, 64'd0);
        chk(result == 64'd0, "R12", "result", result, 64'd0);
        chk(ov_flags == 2'b00, "R12", "ov_flags", {62'b0, ov_flags}, 64'd0);
        chk(so_out == 1'b0, "R12", "so_out", {63'b0, so_out}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // corner sweep: every op, both signedness, overflow recording on
        for (int op = 0; op < 4; op++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        send(corner[i], corner[j], 2'(op), 1'(sg), 1'b1, 1'($urandom()));
                    end
                end
            end
            hold_check();
        end

        // R9: overflow-producing operands with recording off
        send(corner[2], corner[1], 2'd2, 1'b1, 1'b0, 1'b1);
        send(corner[4], corner[3], 2'd0, 1'b1, 1'b0, 1'b0);
        // R5: signed flag ignored on low doubleword
        send(corner[2], corner[1], 2'd2, 1'b0, 1'b1, 1'b1);
        send(corner[3], corner[3], 2'd2, 1'b0, 1'b1, 1'b0);
        hold_check();

        // random mix with gaps
        for (int k = 0; k < 400; k++) begin
            logic [63:0] a, b;
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            if (k % 5 == 1) a = a >> ($urandom() % 64);
            if (k % 7 == 2) b = b >> ($urandom() % 64);
            send(a, b, 2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
            if ($urandom() % 9 == 0) idle(1 + $urandom() % 2);
        end
        hold_check();

        chk(q_res.size() == 0, "R1", "pending results", 64'(q_res.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule